// File: doc/BRIEF.md
# I2C Target Byte Receiver with Acknowledge

This block is the receive side of an I2C target. SCL and SDA are first brought into the system clock domain. The block then waits for a START condition. After START it collects the first eight bits on rising SCL edges, most significant bit first. It compares the seven upper bits with a programmable own address. If they match, the block accepts that byte and every data byte after it until the next START or STOP. Each accepted byte is acknowledged on the ninth clock by pulling SDA low.

Accepted bytes move from the shift register into a one-byte holding buffer. This makes a double buffer: the next byte can arrive while software still has to read the last one. A buffer-full flag, a sticky overflow flag and an interrupt flag report what happened. A small status group reports START seen, STOP seen, the kind of the last byte and the direction bit of the address. The host side is a register-style strobe interface. It reads the buffer and clears the flags. The block only receives. It does not transmit, does not stretch the clock and handles 7-bit addresses only.

Top module: `i2c_target_rx`

## Requirements
- R1: After `enable` goes high, no byte is shifted, acknowledged or flagged until a START condition (SDA falling while SCL is high) has been seen.
- R2: SDA is sampled on each rising SCL edge, most significant bit first, and an accepted byte appears unchanged on `rx_data`.
- R3: Bits [7:1] of the first byte after START are compared with `own_addr`. On a mismatch there is no acknowledge, no buffer load and no interrupt, and the bus is ignored until the next START.
- R4: An accepted byte that arrives while `buf_full` and `ovf` are both clear is loaded into the buffer and sets `buf_full`. `sda_oe` is high from the falling edge of the 8th SCL to the falling edge of the 9th SCL, and low at all other times.
- R5: `irq` rises only after the falling edge of the 9th SCL of an accepted byte. It is still low while the acknowledge is being driven. `irq` stays set until `clr_irq` is pulsed.
- R6: After a matching address, each further data byte is accepted, loaded and acknowledged in the same way. The next byte may be shifted in while the previous one is still in the buffer.
- R7: An accepted byte that completes while `buf_full` is set leaves `rx_data` unchanged. It sets `ovf` and `irq`, and it is not acknowledged.
- R8: An accepted byte that completes while `ovf` is set and `buf_full` is clear is neither loaded nor acknowledged, and `buf_full` stays clear.
- R9: A one-cycle pulse on `rd_strobe` clears `buf_full`. `ovf` is cleared only by a pulse on `clr_ovf`, and reading the buffer leaves it set.
- R10: `st_start` is set by START and cleared by STOP. `st_stop` is set by STOP and cleared by START. `st_data` is 0 after an accepted address byte and 1 after an accepted data byte. `st_rw` holds bit 0 of the last matching address byte.
- R11: START and STOP reset the bit counter. A repeated START in the middle of a byte makes the next eight bits an address byte again.
- R12: While `enable` is low, `sda_oe` stays low and bus activity changes no flag or buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Receiver enable |
| scl_i | input | 1 | SCL line as seen on the bus |
| sda_i | input | 1 | SDA line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| own_addr | input | ADDR_W | 7-bit own address |
| rd_strobe | input | 1 | Buffer read pulse, clears buffer-full |
| clr_ovf | input | 1 | Clears the overflow flag |
| clr_irq | input | 1 | Clears the interrupt flag |
| rx_data | output | 8 | Holding buffer contents |
| buf_full | output | 1 | Buffer holds an unread byte |
| ovf | output | 1 | Receive overflow, sticky |
| irq | output | 1 | Interrupt flag |
| st_start | output | 1 | START seen since last STOP |
| st_stop | output | 1 | STOP seen since last START |
| st_data | output | 1 | Last accepted byte was data (1) or address (0) |
| st_rw | output | 1 | Direction bit of last matching address |

## Verification
The receive path is driven with several kinds of byte. There is a byte with no preceding START, which separates START gating from plain shifting. There are a mismatching and a matching address, which show that only bits [7:1] decide acceptance. Data bytes arrive in both flag states: with the buffer unread, and with only overflow left set. These show the two separate refusal paths and that the old byte is kept. A repeated START inserted after three bits shows that the counter restarts. A disabled pass shows that the block stays silent. The acknowledge is sampled inside the ninth clock and the interrupt both there and after it, which pins down exactly when each one changes.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 2);

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_evt_t;

  function automatic logic addr_hit(input logic [BYTE_W-1:0] first_byte,
                                    input logic [BYTE_W-2:0] addr);
    return first_byte[BYTE_W-1:1] == addr;
  endfunction
endpackage

// File: rtl/i2c_rx_sync.sv
module i2c_rx_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe[0] <= '1;
    else        pipe[0] <= d;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) pipe[s] <= '1;
      else        pipe[s] <= pipe[s-1];
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/i2c_rx_cond.sv
module i2c_rx_cond
  import i2c_rx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scl_s,
  input  logic     sda_s,
  output bus_evt_t evt
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign evt.rise  = scl_s & ~scl_d;
  assign evt.fall  = ~scl_s & scl_d;
  assign evt.start = scl_s & scl_d & sda_d & ~sda_s;
  assign evt.stop  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_rx_byte.sv
module i2c_rx_byte
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  bus_evt_t          evt,
  input  logic              sda_s,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              blocked,
  output logic              cmp_evt,
  output logic              take,
  output logic              is_addr,
  output logic [BYTE_W-1:0] byte_val,
  output logic              ninth_fall,
  output logic              sda_oe
);
  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic              ack_q;
  logic              hit;

  assign byte_val   = shreg_w();
  assign is_addr    = (phase == PH_ADDR);
  assign hit        = addr_hit(byte_val, own_addr);
  assign cmp_evt    = enable && evt.fall && !evt.start && !evt.stop &&
                      cnt == CNT_W'(BYTE_W) && phase != PH_IDLE;
  assign take       = (phase == PH_DATA) || hit;
  assign ninth_fall = enable && evt.fall && cnt == CNT_W'(BYTE_W + 1);
  assign sda_oe     = ack_q;

  logic [BYTE_W-1:0] shreg;
  function automatic logic [BYTE_W-1:0] shreg_w();
    return shreg;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ack_q <= 1'b0;
      shreg <= '0;
    end else if (!enable) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ack_q <= 1'b0;
    end else if (evt.start) begin
      phase <= PH_ADDR;
      cnt   <= '0;
      ack_q <= 1'b0;
    end else if (evt.stop) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      ack_q <= 1'b0;
    end else if (phase != PH_IDLE) begin
      if (evt.rise && cnt < CNT_W'(BYTE_W)) begin
        shreg <= {shreg[BYTE_W-2:0], sda_s};
        cnt   <= cnt + 1'b1;
      end else if (cmp_evt) begin
        cnt   <= cnt + 1'b1;
        ack_q <= take && !blocked;
        if (phase == PH_ADDR)
          phase <= (take && !blocked) ? PH_DATA : PH_IDLE;
      end else if (ninth_fall) begin
        cnt   <= '0;
        ack_q <= 1'b0;
      end
    end

  a_r4_ack_window: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> cnt == CNT_W'(BYTE_W + 1));
  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && evt.start) |=> cnt == '0 && !sda_oe);
  a_r3_miss_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && is_addr && !hit) |=> !sda_oe && phase == PH_IDLE);
  a_r12_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !sda_oe);
endmodule

// File: rtl/i2c_target_rx.sv
module i2c_target_rx
  import i2c_rx_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              rd_strobe,
  input  logic              clr_ovf,
  input  logic              clr_irq,
  output logic [7:0]        rx_data,
  output logic              buf_full,
  output logic              ovf,
  output logic              irq,
  output logic              st_start,
  output logic              st_stop,
  output logic              st_data,
  output logic              st_rw
);
  logic [1:0]        line_s;
  bus_evt_t          evt;
  logic              cmp_evt, take, is_addr, ninth_fall, blocked;
  logic [BYTE_W-1:0] byte_val;
  logic              load, refuse, irq_pend;
  logic [BYTE_W-1:0] rx_buf;

  i2c_rx_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(line_s));

  i2c_rx_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_s(line_s[1]), .sda_s(line_s[0]), .evt(evt));

  i2c_rx_byte #(.ADDR_W(ADDR_W)) u_byte (
    .clk(clk), .rst_n(rst_n), .enable(enable), .evt(evt), .sda_s(line_s[0]),
    .own_addr(own_addr), .blocked(blocked), .cmp_evt(cmp_evt), .take(take),
    .is_addr(is_addr), .byte_val(byte_val), .ninth_fall(ninth_fall),
    .sda_oe(sda_oe));

  assign blocked = buf_full || ovf;
  assign load    = cmp_evt && take && !blocked;
  assign refuse  = cmp_evt && take && blocked;
  assign rx_data = rx_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_buf   <= '0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
      irq_pend <= 1'b0;
    end else begin
      if (load) rx_buf <= byte_val;

      if (load)           buf_full <= 1'b1;
      else if (rd_strobe) buf_full <= 1'b0;

      if (refuse)       ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;

      if (cmp_evt && take)           irq_pend <= 1'b1;
      else if (ninth_fall || evt.start || evt.stop) irq_pend <= 1'b0;

      if (ninth_fall && irq_pend) irq <= 1'b1;
      else if (clr_irq)           irq <= 1'b0;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_start <= 1'b0;
      st_stop  <= 1'b0;
      st_data  <= 1'b0;
      st_rw    <= 1'b0;
    end else if (enable) begin
      if (evt.start) begin
        st_start <= 1'b1;
        st_stop  <= 1'b0;
      end else if (evt.stop) begin
        st_start <= 1'b0;
        st_stop  <= 1'b1;
      end
      if (cmp_evt && take) begin
        st_data <= !is_addr;
        if (is_addr) st_rw <= byte_val[0];
      end
    end

  a_r7_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && take && buf_full) |=> $stable(rx_buf) && ovf && !sda_oe);
  a_r8_ovf_refuse: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt && take && ovf && !buf_full && !rd_strobe) |=> !buf_full && !sda_oe);
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr_ovf) |=> ovf);
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !cmp_evt) |=> !buf_full);
  a_r5_irq_ninth: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ninth_fall));
endmodule

// File: tb/i2c_target_rx_tb.sv
module i2c_target_rx_tb;
  localparam int Q = 8;
  localparam logic [6:0] ADDR = 7'h5A;

  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic rd_strobe = 1'b0, clr_ovf = 1'b0, clr_irq = 1'b0;
  logic sda_oe, buf_full, ovf, irq, st_start, st_stop, st_data, st_rw;
  logic [7:0] rx_data;
  wire  sda_bus = sda_m & ~sda_oe;
  int   total = 0, bad = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  i2c_target_rx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_oe(sda_oe), .own_addr(ADDR), .rd_strobe(rd_strobe), .clr_ovf(clr_ovf),
    .clr_irq(clr_irq), .rx_data(rx_data), .buf_full(buf_full), .ovf(ovf),
    .irq(irq), .st_start(st_start), .st_stop(st_stop), .st_data(st_data),
    .st_rw(st_rw));

  function automatic logic [7:0] addr_byte(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack, output logic irq_mid);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; wq(Q);
    ack = sda_oe; irq_mid = irq;
    scl_m = 1'b1; wq(2*Q); scl_m = 1'b0; wq(Q);
    ack = ack & ~sda_oe;
  endtask

  task automatic drain();
    pulse(rd_strobe); pulse(clr_irq); pulse(clr_ovf);
  endtask

  task automatic t_reset();
    chk("R4 reset sda_oe", sda_oe, 0);
    chk("R9 reset buf_full", buf_full, 0);
    chk("R9 reset ovf", ovf, 0);
    chk("R5 reset irq", irq, 0);
    chk("R10 reset st_start", st_start, 0);
    chk("R10 reset st_stop", st_stop, 0);
  endtask

  task automatic t_no_start();
    logic a, m;
    scl_m = 1'b0; wq(Q);
    send_byte(addr_byte(ADDR, 1'b0), a, m);
    chk("R1 no ack without START", a, 0);
    chk("R1 no buffer without START", buf_full, 0);
    chk("R1 no irq without START", irq, 0);
    bus_stop();
  endtask

  task automatic t_mismatch();
    logic a, m;
    bus_start();
    chk("R10 st_start after START", st_start, 1);
    send_byte(addr_byte(7'h5B, 1'b0), a, m);
    chk("R3 mismatch no ack", a, 0);
    chk("R3 mismatch no buffer", buf_full, 0);
    chk("R3 mismatch no irq", irq, 0);
    send_byte(8'hA5, a, m);
    chk("R3 data after mismatch ignored", a, 0);
    chk("R3 buffer after mismatch", buf_full, 0);
    bus_stop();
  endtask

  task automatic t_write();
    logic a, m;
    bus_start();
    send_byte(addr_byte(ADDR, 1'b0), a, m);
    chk("R4 address acked", a, 1);
    chk("R5 irq low during ack", m, 0);
    chk("R5 irq after ninth", irq, 1);
    chk("R2 address byte buffered", rx_data, 8'hB4);
    chk("R4 buf_full set", buf_full, 1);
    chk("R10 st_data address", st_data, 0);
    chk("R10 st_rw write", st_rw, 0);
    pulse(rd_strobe);
    chk("R9 read clears buf_full", buf_full, 0);
    pulse(clr_irq);
    chk("R5 clr_irq clears", irq, 0);
    send_byte(8'h3C, a, m);
    chk("R6 data acked", a, 1);
    chk("R6 data buffered", rx_data, 8'h3C);
    chk("R10 st_data data", st_data, 1);
  endtask

  task automatic t_overflow();
    logic a, m;
    send_byte(8'hC3, a, m);
    chk("R7 no ack when full", a, 0);
    chk("R7 old byte kept", rx_data, 8'h3C);
    chk("R7 ovf set", ovf, 1);
    chk("R7 irq set", irq, 1);
    pulse(rd_strobe); pulse(clr_irq);
    chk("R9 ovf survives read", ovf, 1);
    send_byte(8'h11, a, m);
    chk("R8 no ack with ovf", a, 0);
    chk("R8 buffer not loaded", rx_data, 8'h3C);
    chk("R8 buf_full stays clear", buf_full, 0);
    pulse(clr_ovf);
    chk("R9 clr_ovf clears", ovf, 0);
    send_byte(8'h22, a, m);
    chk("R6 ack after recovery", a, 1);
    chk("R6 recovered byte", rx_data, 8'h22);
    bus_stop();
    chk("R10 st_stop after STOP", st_stop, 1);
    chk("R10 st_start cleared by STOP", st_start, 0);
  endtask

  task automatic t_read_dir();
    logic a, m;
    drain();
    bus_start();
    send_byte(addr_byte(ADDR, 1'b1), a, m);
    chk("R10 read address acked", a, 1);
    chk("R10 st_rw read", st_rw, 1);
    chk("R10 st_stop cleared by START", st_stop, 0);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a, m;
    drain();
    bus_start();
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start();
    send_byte(addr_byte(ADDR, 1'b0), a, m);
    chk("R11 restart gives fresh address", a, 1);
    chk("R11 address after restart", rx_data, 8'hB4);
    bus_stop();
  endtask

  task automatic t_disabled();
    logic a, m;
    drain();
    enable = 1'b0;
    bus_start();
    send_byte(addr_byte(ADDR, 1'b0), a, m);
    chk("R12 no ack when disabled", a, 0);
    chk("R12 no buffer when disabled", buf_full, 0);
    chk("R12 no irq when disabled", irq, 0);
    bus_stop();
    enable = 1'b1;
  endtask

  initial begin
    wq(4); rst_n = 1'b1; wq(2);
    t_reset();
    enable = 1'b1; wq(2);
    t_no_start();
    t_mismatch();
    t_write();
    t_overflow();
    t_read_dir();
    t_restart();
    t_disabled();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule